// File: doc/BRIEF.md
# Slotted Frame Serial Multiplexer

The block merges 32-bit words from 18 independent front-end channels into one serial bit stream. Each channel has already been deserialized and moved into the system clock domain. It presents a word with a one-cycle valid strobe, and the word waits in that channel's own 16-word FIFO.

The serial output repeats a frame of 19 words back to back. An all-zero separator word comes first. It is followed by one slot per channel, channel 0 first and channel 17 last. Only the slot position after the separator identifies a channel, so a slot whose FIFO is empty carries a nonzero filler word, and real data is never allowed to be all zeros.

Every word is sent as 35 bits, one bit per clock: a start bit, the data bits LSB first, an even parity bit and a stop bit. Sticky per-channel flags report dropped words and all-zero input words.

Top module: `slot_frame_mux`

## Requirements
- R1: While reset is held, and in the cycle right after reset is released, `serOut` is 1 and both flag vectors are 0.
- R2: The first word after reset, and every 19th word after it, is the separator: 32 data bits all zero.
- R3: Each word on the line is 35 bits in this order: start bit 0, data bit 0 through data bit 31, a parity bit that makes the number of ones among the 32 data bits plus parity even, then stop bit 1.
- R4: Word k of a frame (k = 1..18) carries the oldest pending word of channel k-1 and removes it from that FIFO. A channel's words leave in the order they arrived.
- R5: A slot whose channel FIFO is empty when the slot is loaded carries the filler word 32'h8000A5A5. Bit 31 of the filler is set as the empty marker.
- R6: An input word of all zeros is stored as the filler word, and it sets that channel's sticky `zeroErr` bit.
- R7: Each channel FIFO holds 16 words. A word offered while 16 are held is dropped and sets that channel's sticky `ovfErr` bit. The 16 held words still come out intact.
- R8: Words follow one another with no idle bits, so separator start bits are exactly 19 x 35 = 665 clocks apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; one serial bit per cycle |
| rstN | input | 1 | Active-low synchronous reset |
| chData | input | 18x32 | Per-channel input word, index = channel |
| chValid | input | 18 | Per-channel write strobe, one word per cycle |
| serOut | output | 1 | Serial frame stream |
| ovfErr | output | 18 | Sticky per-channel FIFO overflow flag |
| zeroErr | output | 18 | Sticky per-channel all-zero input flag |

## Verification
The bench decodes the line bit by bit and checks every word against per-channel expected queues. It drives sparse single words on a few channels, which shows whether slot position maps to the right channel. It drives one word on every channel at once, which exposes swapped or shifted slots. It also drives a run of words into one channel that spans many frames, which shows the one-word-per-frame drain order, and idle frames, which leave only filler. An all-zero word and a 17-word burst probe the filler substitution, the drop rule and the flag isolation between channels.

// File: rtl/slot_mux_pkg.sv
package slot_mux_pkg;
  typedef struct packed {
    logic       load;   // load next word into the shifter this cycle
    logic       isSep;  // next word is the separator
    logic [7:0] chSel;  // channel owning the next slot
  } mux_strobe_t;
endpackage

// File: rtl/slot_chan_fifo.sv
module slot_chan_fifo #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              push,
  input  logic [DATA_W-1:0] din,
  input  logic              pop,
  output logic [DATA_W-1:0] dout,
  output logic              empty,
  output logic              full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [CNT_W-1:0]  count;
  logic              doPush, doPop;

  assign empty  = (count == '0);
  assign full   = (count == FULL_CNT);
  assign doPush = push && !full;
  assign doPop  = pop && !empty;
  assign dout   = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == LAST_PTR) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == LAST_PTR) ? '0 : rdPtr + 1'b1;
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/slot_mux_ctrl.sv
module slot_mux_ctrl
  import slot_mux_pkg::*;
#(
  parameter int NUM_CH    = 18,
  parameter int WORD_BITS = 35,
  parameter int BIT_W     = 6,
  parameter int SLOT_W    = 5
) (
  input  logic              clk,
  input  logic              rstN,
  output mux_strobe_t       strobe,
  output logic [BIT_W-1:0]  bitCnt,
  output logic [SLOT_W-1:0] slotCnt
);
  localparam logic [BIT_W-1:0]  LAST_BIT  = BIT_W'(WORD_BITS - 1);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_CH);

  logic [SLOT_W-1:0] nextSlot;
  logic [SLOT_W-1:0] nextChan;

  assign nextSlot = (slotCnt == LAST_SLOT) ? '0 : slotCnt + 1'b1;
  assign nextChan = nextSlot - 1'b1;

  // bitCnt names the bit currently on the line; reset parks it on a stop bit
  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitCnt  <= LAST_BIT;
      slotCnt <= LAST_SLOT;
    end else if (bitCnt == LAST_BIT) begin
      bitCnt  <= '0;
      slotCnt <= nextSlot;
    end else begin
      bitCnt  <= bitCnt + 1'b1;
    end
  end

  always_comb begin
    strobe.load  = (bitCnt == LAST_BIT);
    strobe.isSep = (nextSlot == '0);
    strobe.chSel = 8'(nextChan);
  end
endmodule

// File: rtl/slot_mux_datapath.sv
module slot_mux_datapath
  import slot_mux_pkg::*;
#(
  parameter int               NUM_CH    = 18,
  parameter int               DATA_W    = 32,
  parameter int               DEPTH     = 16,
  parameter int               WORD_BITS = 35,
  parameter logic [DATA_W-1:0] FILL_WORD = 32'h8000_A5A5
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [NUM_CH-1:0][DATA_W-1:0]  chData,
  input  logic [NUM_CH-1:0]              chValid,
  input  mux_strobe_t                    strobe,
  output logic                           serOut,
  output logic [NUM_CH-1:0]              popVec,
  output logic [NUM_CH-1:0]              ovfErr,
  output logic [NUM_CH-1:0]              zeroErr
);
  logic [NUM_CH-1:0][DATA_W-1:0] headWord;
  logic [NUM_CH-1:0]             emptyVec;
  logic [DATA_W-1:0]             pickWord, selWord;
  logic [WORD_BITS-1:0]          shReg;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic              isZero, fullQ, ovfQ, zeroQ;
    logic [DATA_W-1:0] inWord;

    assign isZero    = (chData[i] == '0);
    assign inWord    = isZero ? FILL_WORD : chData[i];
    assign popVec[i] = strobe.load && !strobe.isSep &&
                       (strobe.chSel == 8'(i)) && !emptyVec[i];

    slot_chan_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
      .clk   (clk),
      .rstN  (rstN),
      .push  (chValid[i]),
      .din   (inWord),
      .pop   (popVec[i]),
      .dout  (headWord[i]),
      .empty (emptyVec[i]),
      .full  (fullQ)
    );

    always_ff @(posedge clk) begin
      if (!rstN) begin
        ovfQ  <= 1'b0;
        zeroQ <= 1'b0;
      end else begin
        if (chValid[i] && fullQ)  ovfQ  <= 1'b1;
        if (chValid[i] && isZero) zeroQ <= 1'b1;
      end
    end

    assign ovfErr[i]  = ovfQ;
    assign zeroErr[i] = zeroQ;
  end

  always_comb begin
    pickWord = FILL_WORD;
    for (int i = 0; i < NUM_CH; i++) begin
      if (strobe.chSel == 8'(i)) pickWord = emptyVec[i] ? FILL_WORD : headWord[i];
    end
    selWord = strobe.isSep ? '0 : pickWord;
  end

  // bit 0 of the shifter is the line; ones shift in behind the stop bit
  always_ff @(posedge clk) begin
    if (!rstN)            shReg <= '1;
    else if (strobe.load) shReg <= {1'b1, ^selWord, selWord, 1'b0};
    else                  shReg <= {1'b1, shReg[WORD_BITS-1:1]};
  end

  assign serOut = shReg[0];
endmodule

// File: rtl/slot_frame_mux.sv
module slot_frame_mux
  import slot_mux_pkg::*;
#(
  parameter int               NUM_CH     = 18,
  parameter int               DATA_W     = 32,
  parameter int               FIFO_DEPTH = 16,
  parameter logic [DATA_W-1:0] FILL_WORD  = 32'h8000_A5A5
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_CH-1:0][DATA_W-1:0] chData,
  input  logic [NUM_CH-1:0]             chValid,
  output logic                          serOut,
  output logic [NUM_CH-1:0]             ovfErr,
  output logic [NUM_CH-1:0]             zeroErr
);
  localparam int WORD_BITS = DATA_W + 3;
  localparam int BIT_W     = $clog2(WORD_BITS);
  localparam int SLOT_W    = $clog2(NUM_CH + 1);

  mux_strobe_t       strobe;
  logic [BIT_W-1:0]  bitCnt;
  logic [SLOT_W-1:0] slotCnt;
  logic [NUM_CH-1:0] popVec;

  slot_mux_ctrl #(
    .NUM_CH(NUM_CH), .WORD_BITS(WORD_BITS), .BIT_W(BIT_W), .SLOT_W(SLOT_W)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .bitCnt  (bitCnt),
    .slotCnt (slotCnt)
  );

  slot_mux_datapath #(
    .NUM_CH(NUM_CH), .DATA_W(DATA_W), .DEPTH(FIFO_DEPTH),
    .WORD_BITS(WORD_BITS), .FILL_WORD(FILL_WORD)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .chData  (chData),
    .chValid (chValid),
    .strobe  (strobe),
    .serOut  (serOut),
    .popVec  (popVec),
    .ovfErr  (ovfErr),
    .zeroErr (zeroErr)
  );
endmodule

// File: rtl/slot_frame_mux_chk.sv
module slot_frame_mux_chk #(
  parameter int NUM_CH = 18,
  parameter int BIT_W  = 6,
  parameter int SLOT_W = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              serOut,
  input logic [BIT_W-1:0]  bitCnt,
  input logic [SLOT_W-1:0] slotCnt,
  input logic [NUM_CH-1:0] popVec,
  input logic [NUM_CH-1:0] ovfErr,
  input logic [NUM_CH-1:0] zeroErr
);
  localparam logic [BIT_W-1:0] STOP_POS = BIT_W'(34);
  localparam logic [BIT_W-1:0] DATA_END = BIT_W'(32);

  p_start_low_r3: assert property (@(posedge clk) disable iff (!rstN)
    (bitCnt == '0) |-> !serOut);

  p_stop_high_r3: assert property (@(posedge clk) disable iff (!rstN)
    (bitCnt == STOP_POS) |-> serOut);

  p_sep_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    (slotCnt == '0 && bitCnt != '0 && bitCnt <= DATA_END) |-> !serOut);

  p_no_gap_r8: assert property (@(posedge clk) disable iff (!rstN)
    (bitCnt == STOP_POS) |=> (bitCnt == '0));

  p_single_pop_r4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(popVec));

  p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    ((ovfErr & $past(ovfErr)) == $past(ovfErr)));

  p_zero_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    ((zeroErr & $past(zeroErr)) == $past(zeroErr)));
endmodule

bind slot_frame_mux slot_frame_mux_chk #(
  .NUM_CH(NUM_CH), .BIT_W(BIT_W), .SLOT_W(SLOT_W)
) u_chk (.*);

// File: tb/slot_frame_mux_test.sv
`timescale 1ns/1ps
module slot_frame_mux_test;
  localparam int NCH = 18;
  localparam int DW  = 32;
  localparam logic [DW-1:0] FILL = 32'h8000_A5A5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NCH-1:0][DW-1:0] chData = '0;
  logic [NCH-1:0] chValid = '0;
  logic serOut;
  logic [NCH-1:0] ovfErr, zeroErr;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [DW-1:0] expQ [NCH][$];
  event sepSeen;

  always #2.5 clk = ~clk;

  slot_frame_mux uut (
    .clk(clk), .rstN(rstN), .chData(chData), .chValid(chValid),
    .serOut(serOut), .ovfErr(ovfErr), .zeroErr(zeroErr)
  );

  task automatic check(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // ---------------- monitor: decode the line ----------------
  logic [34:0] bits;
  int bitIdx = -1;
  int wordIdx = 0;
  int cycleCnt = 0;
  int lastSep = 0;
  bit seenFirst = 0;
  bit expectStart = 0;

  task automatic evalWord();
    logic [DW-1:0] data;
    logic [DW-1:0] exp;
    int ch;
    data = bits[32:1];
    check(bits[0] == 1'b0, "R3 start bit", 64'(bits[0]), 64'd0);
    check(bits[34] == 1'b1, "R3 stop bit", 64'(bits[34]), 64'd1);
    check(bits[33] == ^data, "R3 even parity", 64'(bits[33]), 64'(^data));
    if (wordIdx == 0) begin
      check(data == '0, "R2 separator", 64'(data), 64'd0);
    end else begin
      ch = wordIdx - 1;
      if (expQ[ch].size() > 0) begin
        exp = expQ[ch].pop_front();
        check(data == exp, $sformatf("R4 slot data ch%0d", ch), 64'(data), 64'(exp));
      end else begin
        check(data == FILL, $sformatf("R5 filler ch%0d", ch), 64'(data), 64'(FILL));
      end
    end
  endtask

  always @(negedge clk) begin
    if (!rstN) begin
      bitIdx = -1; wordIdx = 0; expectStart = 0; seenFirst = 0; cycleCnt = 0;
    end else begin
      cycleCnt++;
      if (bitIdx < 0) begin
        if (serOut == 1'b0) begin
          bits[0] = 1'b0;
          bitIdx = 1;
          if (wordIdx == 0) begin
            if (seenFirst)
              check(cycleCnt - lastSep == 665, "R8 frame period",
                    64'(cycleCnt - lastSep), 64'd665);
            lastSep = cycleCnt;
            seenFirst = 1;
            ->sepSeen;
          end
        end else if (expectStart) begin
          check(1'b0, "R8 idle gap between words", 64'(serOut), 64'd0);
          expectStart = 0;
        end
      end else begin
        bits[bitIdx] = serOut;
        bitIdx++;
        if (bitIdx == 35) begin
          evalWord();
          bitIdx = -1;
          expectStart = 1;
          wordIdx = (wordIdx + 1) % 19;
        end
      end
    end
  end

  // ---------------- driver ----------------
  logic [NCH-1:0] expOvf = '0;
  logic [NCH-1:0] expZero = '0;

  task automatic modelPush(input int ch, input logic [DW-1:0] w);
    if (w == '0) expZero[ch] = 1'b1;
    if (expQ[ch].size() >= 16) expOvf[ch] = 1'b1;
    else expQ[ch].push_back((w == '0) ? FILL : w);
  endtask

  // one cycle: every channel in mask offers base + 0x100*ch
  task automatic pushMask(input logic [NCH-1:0] mask, input logic [DW-1:0] base);
    @(negedge clk);
    chValid = mask;
    for (int ch = 0; ch < NCH; ch++) begin
      if (mask[ch]) begin
        chData[ch] = base + DW'(ch * 256);
        modelPush(ch, chData[ch]);
      end
    end
  endtask

  task automatic pushWord(input int ch, input logic [DW-1:0] w);
    @(negedge clk);
    chValid = '0;
    chValid[ch] = 1'b1;
    chData[ch] = w;
    modelPush(ch, w);
  endtask

  task automatic idleIn();
    @(negedge clk);
    chValid = '0;
  endtask

  initial begin
    // R1: reset state
    repeat (4) @(negedge clk);
    check(serOut == 1'b1, "R1 line high in reset", 64'(serOut), 64'd1);
    check(ovfErr == '0, "R1 ovfErr clear", 64'(ovfErr), 64'd0);
    check(zeroErr == '0, "R1 zeroErr clear", 64'(zeroErr), 64'd0);
    rstN = 1'b1;
    #1;
    check(serOut == 1'b1, "R1 line high after release", 64'(serOut), 64'd1);

    // sparse channels (R4, R5)
    @(sepSeen);
    pushWord(0, 32'h1234_5678);
    pushWord(5, 32'h0000_0001);
    pushWord(17, 32'hFFFF_FFFF);
    idleIn();

    // every channel at once (R4)
    @(sepSeen);
    pushMask('1, 32'h0A00_0003);
    idleIn();

    // several words in one channel drain one per frame (R4)
    @(sepSeen);
    pushWord(3, 32'h3333_0001);
    pushWord(3, 32'h3333_0002);
    pushWord(3, 32'h3333_0003);
    idleIn();

    // all-zero input becomes filler, flags its channel only (R6)
    @(sepSeen);
    pushWord(7, 32'h0);
    pushWord(7, 32'h7777_0007);
    idleIn();
    @(negedge clk);
    check(zeroErr == expZero, "R6 zeroErr after zero word", 64'(zeroErr), 64'(expZero));
    check(ovfErr == '0, "R7 no overflow yet", 64'(ovfErr), 64'd0);

    // overflow: 17 words into channel 9 within one frame (R7)
    @(sepSeen);
    for (int k = 0; k < 17; k++) pushWord(9, 32'h9900_0000 + DW'(k + 1));
    idleIn();
    @(negedge clk);
    check(ovfErr == expOvf, "R7 ovfErr after burst", 64'(ovfErr), 64'(expOvf));
    check(expOvf == (NCH'(1) << 9), "R7 model drops one word", 64'(expOvf), 64'(NCH'(1) << 9));

    // drain
    for (int f = 0; f < 20; f++) @(sepSeen);
    for (int ch = 0; ch < NCH; ch++)
      check(expQ[ch].size() == 0, $sformatf("R4 ch%0d drained", ch),
            64'(expQ[ch].size()), 64'd0);
    check(ovfErr == expOvf, "R7 ovfErr sticky", 64'(ovfErr), 64'(expOvf));
    check(zeroErr == expZero, "R6 zeroErr sticky", 64'(zeroErr), 64'(expZero));

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule